// File: doc/BRIEF.md
# External Static Memory Access Sequencer with Wait Input

This block carries out single read and write accesses to an asynchronous static memory device. A requester presents one access at a time: an address, write data, a direction bit and a chip select index. The block then walks the selected chip select through three phases of its controlling strobe. In setup, the chip select and address are driven. In pulse, the read or write strobe is low. In hold, the strobe is high again but the chip select and address are still driven. The length of each phase comes from per-chip-select configuration inputs.

An active-low wait input from the device can stretch the pulse phase. Each chip select has a 2-bit wait mode: disabled, frozen or ready. The wait input passes through a two-flop synchroniser and only affects the pulse phase. After a read, each chip select keeps a data-float timer. A write to that same chip select does not begin its setup until the timer has run out, so the device has time to release the shared data lines.

Top module: `extmem_seq`

## Requirements
- R1: During and right after reset, every chip select, the read strobe and the write strobe are high, the data output enable is low, `done` is low and `req_ready` is high.
- R2: An accepted access asserts only its own chip select, low-active. Chip select `k` is bit `k` of `mem_cs_n`. The access lasts setup cycles, then pulse cycles with its strobe low, then hold cycles. Each count is a 4-bit field at bits `[4k+3:4k]` of its configuration vector, and a pulse count of 0 acts as 1. `mem_addr` holds the request address for the whole access, and the read and write strobes are never low together.
- R3: The wait mode of chip select `k` is at `cfg_wmode[2k+1:2k]`. Code 00 (and 01) disables wait, 10 selects frozen mode and 11 selects ready mode. With wait disabled, the pulse lasts exactly its programmed count whatever `mem_wait_n` does.
- R4: In frozen mode, the pulse counter stops while the synchronised wait is low and resumes from the same count once it is high. Suppose wait is low from before the pulse and is raised in pulse cycle `r`. The pulse then lasts `r + 1 + P` cycles, where P is the pulse count.
- R5: In ready mode, the pulse counter keeps running, and the pulse ends once the count is reached and the synchronised wait is high. Under the same stimulus as R4, it lasts `max(P, r + 2)` cycles.
- R6: `mem_wait_n` is synchronised by two flops. A pulse under an enabled wait mode ends no earlier than two cycles after the cycle in which `mem_wait_n` rose.
- R7: A low `mem_wait_n` during setup, hold or idle leaves the phase lengths unchanged.
- R8: With wait enabled, a programmed hold count of 0 is raised to 1 hold cycle.
- R9: Chip select `k` has a data-float count F at `cfg_float[4k+3:4k]` and an effective hold H. When a write to `k` is requested in the first idle cycle after a read on `k`, it waits `max(F-H-1, 0)` extra cycles before its chip select is driven. The first write cycle therefore comes `max(F+1, H+2)` cycles after the last read strobe cycle. A write to a different chip select is not delayed.
- R10: `rd_data` takes `mem_din` as sampled at the end of the last read pulse cycle. `done` is high for exactly one cycle: the last hold cycle, or the last pulse cycle when the hold count is 0.
- R11: `mem_oe` is high and `mem_dout` equals the write data from the first setup cycle through the last hold cycle of a write. `mem_oe` is low during reads, float cycles and idle.
- R12: A request is accepted only while `req_ready` is high, which is only when idle. A request held during an access neither changes `mem_addr` nor starts a second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Chip select index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | Access completes this cycle |
| rd_data | output | DW | Captured read data |
| cfg_setup | input | NCS*TW | Setup cycles per chip select |
| cfg_pulse | input | NCS*TW | Pulse cycles per chip select |
| cfg_hold | input | NCS*TW | Hold cycles per chip select |
| cfg_float | input | NCS*TW | Data-float cycles per chip select |
| cfg_wmode | input | 2*NCS | Wait mode per chip select |
| mem_addr | output | AW | Device address |
| mem_cs_n | output | NCS | Chip selects, low-active |
| mem_rd_n | output | 1 | Read strobe, low-active |
| mem_wr_n | output | 1 | Write strobe, low-active |
| mem_oe | output | 1 | Data output enable |
| mem_dout | output | DW | Data driven to the device |
| mem_din | input | DW | Data from the device |
| mem_wait_n | input | 1 | Device wait, low-active |

## Verification
The assertions assume that the configuration of a chip select does not change while an access on it is running. They also assume that `req_cs` names an existing chip select. The bench changes configuration only between accesses and only uses indices 0 and 1. It drives `mem_wait_n` low only at chosen points relative to the observed phases. When the wait must be seen from the first pulse cycle, the bench lowers `mem_wait_n` three cycles before the request. Writes that test the float gap are issued in the first idle cycle after the read.

// File: rtl/extmem_seq.sv
module extmem_seq #(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int NCS = 2,
  parameter int TW  = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  input  logic [NCS*TW-1:0] cfg_setup,
  input  logic [NCS*TW-1:0] cfg_pulse,
  input  logic [NCS*TW-1:0] cfg_hold,
  input  logic [NCS*TW-1:0] cfg_float,
  input  logic [2*NCS-1:0]  cfg_wmode,
  output logic [AW-1:0]     mem_addr,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              mem_oe,
  output logic [DW-1:0]     mem_dout,
  input  logic [DW-1:0]     mem_din,
  input  logic              mem_wait_n
);

  typedef enum logic [2:0] {S_IDLE, S_FLOAT, S_SETUP, S_PULSE, S_HOLD} st_t;

  st_t            st;
  logic [CSW-1:0] cs_q;
  logic           wr_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [TW-1:0]  cnt;
  logic           ws1, ws2;
  logic [TW-1:0]  ftmr [NCS];

  logic [CSW-1:0] sel;
  logic [TW-1:0]  s_len, p_raw, p_last, h_raw, h_len;
  logic [1:0]     wmode;
  logic           wen, frz, wait_act, busy;
  logic           s_end, p_end, h_end;
  st_t            start_st;

  assign sel      = (st == S_IDLE) ? req_cs : cs_q;
  assign s_len    = cfg_setup[sel*TW +: TW];
  assign p_raw    = cfg_pulse[sel*TW +: TW];
  assign h_raw    = cfg_hold[sel*TW +: TW];
  assign wmode    = cfg_wmode[sel*2 +: 2];
  assign wen      = wmode[1];
  assign frz      = (wmode == 2'b10);
  assign p_last   = (p_raw == '0) ? '0 : p_raw - TW'(1);
  assign h_len    = (wen && h_raw == '0) ? TW'(1) : h_raw;
  assign wait_act = wen && !ws2;
  assign busy     = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
  assign start_st = (s_len == '0) ? S_PULSE : S_SETUP;

  assign s_end = (st == S_SETUP) && (cnt == s_len - TW'(1));
  assign p_end = (st == S_PULSE) && (cnt == p_last) && !wait_act;
  assign h_end = (st == S_HOLD)  && (cnt == h_len - TW'(1));

  assign req_ready = (st == S_IDLE);
  assign done      = h_end || (p_end && h_len == '0);
  assign mem_addr  = addr_q;
  assign mem_dout  = wdata_q;
  assign mem_oe    = busy && wr_q;
  assign mem_rd_n  = !((st == S_PULSE) && !wr_q);
  assign mem_wr_n  = !((st == S_PULSE) && wr_q);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign mem_cs_n[i] = !(busy && cs_q == CSW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cs_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cnt     <= '0;
      rd_data <= '0;
      ws1     <= 1'b1;
      ws2     <= 1'b1;
    end else begin
      ws1 <= mem_wait_n;
      ws2 <= ws1;
      case (st)
        S_IDLE: if (req_valid) begin
          cs_q    <= req_cs;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= '0;
          st      <= (req_write && ftmr[req_cs] > TW'(1)) ? S_FLOAT : start_st;
        end
        S_FLOAT: if (ftmr[cs_q] <= TW'(1)) begin
          st  <= start_st;
          cnt <= '0;
        end
        S_SETUP: if (s_end) begin
          st  <= S_PULSE;
          cnt <= '0;
        end else cnt <= cnt + TW'(1);
        S_PULSE: if (p_end) begin
          if (!wr_q) rd_data <= mem_din;
          cnt <= '0;
          st  <= (h_len == '0) ? S_IDLE : S_HOLD;
        end else if (cnt != p_last && !(frz && wait_act)) cnt <= cnt + TW'(1);
        S_HOLD: if (h_end) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else cnt <= cnt + TW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCS; i++) ftmr[i] <= '0;
    end else begin
      for (int i = 0; i < NCS; i++) begin
        if (p_end && !wr_q && cs_q == CSW'(i)) ftmr[i] <= cfg_float[i*TW +: TW];
        else if (ftmr[i] != '0) ftmr[i] <= ftmr[i] - TW'(1);
      end
    end
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_n || mem_wr_n);
  a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> !mem_oe);
  a_r8_hold_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_rd_n) || $rose(mem_wr_n)) && cfg_wmode[2*cs_q+1] |-> (mem_cs_n != '1));
  a_r4_frozen_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE) && frz && wait_act |=> (st == S_PULSE) && $stable(cnt));
  a_r9_float_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SETUP) || (st == S_PULSE)) && wr_q |-> (ftmr[cs_q] == '0));
  a_r10_done_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n != '1));
  a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n == '1) && mem_rd_n && mem_wr_n);

endmodule

// File: tb/extmem_seq_bench.sv
module extmem_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [0:0] req_cs = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, done;
  logic [7:0] rd_data, mem_addr, mem_dout;
  logic [7:0] din = '0;
  logic [1:0] mem_cs_n;
  logic mem_rd_n, mem_wr_n, mem_oe;
  logic wait_n = 1'b1;

  logic [3:0] s0 = 1, p0 = 1, h0 = 1, f0 = 0;
  logic [1:0] m0 = 2'b00;
  localparam logic [3:0] S1 = 1, P1 = 2, H1 = 1, F1 = 0;
  localparam logic [1:0] M1 = 2'b00;

  int nchk = 0, nerr = 0;
  int prev_rd_cs = -1, prev_he = 0;

  extmem_seq u_extmem_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .cfg_setup({S1, s0}), .cfg_pulse({P1, p0}), .cfg_hold({H1, h0}),
    .cfg_float({F1, f0}), .cfg_wmode({M1, m0}),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_oe(mem_oe), .mem_dout(mem_dout), .mem_din(din), .mem_wait_n(wait_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic access(input int cs, input bit wr, input logic [7:0] a, input logic [7:0] wd,
                        input int rel, input bit ws_setup, input bit ws_hold);
    int S, P, H, F, Pe, He, plen, eidle;
    bit en, fz;
    int idle = 0, ns = 0, np = 0, nh = 0, ndone = 0, bad_sig = 0, bad_oe = 0, ph = 0;
    string ptag;
    S  = (cs == 0) ? int'(s0) : int'(S1);
    P  = (cs == 0) ? int'(p0) : int'(P1);
    H  = (cs == 0) ? int'(h0) : int'(H1);
    F  = (cs == 0) ? int'(f0) : int'(F1);
    en = (cs == 0) ? m0[1] : M1[1];
    fz = (cs == 0) ? (m0 == 2'b10) : (M1 == 2'b10);
    Pe = (P == 0) ? 1 : P;
    He = (en && H == 0) ? 1 : H;
    if (en && rel > 0) plen = fz ? rel + 1 + Pe : imax(Pe, rel + 2);
    else plen = Pe;
    eidle = (wr && prev_rd_cs == cs) ? imax(F - prev_he - 1, 0) : 0;
    if (!en || rel == 0) ptag = "R3 pulse";
    else if (fz) ptag = "R4 frozen pulse";
    else ptag = "R5 R6 ready pulse";

    if (rel > 0 || ws_setup) begin
      wait_n = 1'b0;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = 1'(cs); req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (mem_cs_n == 2'b11) begin
        if (ph == 0) idle++;
        else bad_sig++;
      end else begin
        if (mem_cs_n != ~(2'b01 << cs)) bad_sig++;
        if (mem_addr != a) bad_sig++;
        if (!mem_rd_n && !mem_wr_n) bad_sig++;
        if (mem_oe != wr) bad_oe++;
        if (wr && mem_dout != wd) bad_oe++;
        if ((wr ? !mem_wr_n : !mem_rd_n)) begin
          np++; ph = 2;
          din = a + 8'(np);
          if (rel > 0 && np == rel) wait_n = 1'b1;
        end else if (ph >= 2) begin
          nh++; ph = 3;
          if (ws_hold && nh == 1) wait_n = 1'b0;
        end else begin
          ns++; ph = 1;
          if (ws_setup && ns == 1) wait_n = 1'b1;
        end
        if (done) begin
          ndone++;
          break;
        end
      end
      if (ph == 0 && mem_oe) bad_oe++;
      @(negedge clk);
    end
    wait_n = 1'b1;
    @(posedge clk); #1;
    chk(idle == eidle, wr ? "R9 float gap" : "R9 no gap", idle, eidle);
    chk(ns == S, ws_setup ? "R7 setup" : "R2 setup", ns, S);
    chk(np == plen, ws_setup ? "R7 pulse" : ptag, np, plen);
    chk(nh == He, ws_hold ? "R7 hold" : ((en && H == 0) ? "R8 hold" : "R2 hold"), nh, He);
    chk(ndone == 1, "R10 done", ndone, 1);
    chk(bad_sig == 0, "R2 pins", bad_sig, 0);
    chk(bad_oe == 0, "R11 data drive", bad_oe, 0);
    if (!wr) chk(rd_data == a + 8'(plen), "R10 read capture", int'(rd_data), int'(a + 8'(plen)));
    prev_rd_cs = wr ? -1 : cs;
    prev_he = He;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R2 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [1:0] modes [3];
    int rels [3];
    logic [7:0] ad;
    modes[0] = 2'b00; modes[1] = 2'b10; modes[2] = 2'b11;
    rels[0] = 0; rels[1] = 1; rels[2] = 3;
    ad = 8'h10;

    repeat (3) @(negedge clk);
    chk(mem_cs_n == 2'b11 && mem_rd_n && mem_wr_n, "R1 strobes in reset", int'(mem_cs_n), 3);
    chk(!mem_oe && !done && req_ready, "R1 idle flags in reset", int'({mem_oe, done, req_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n == 2'b11 && !mem_oe && req_ready, "R1 after reset", int'({mem_cs_n, mem_oe}), 6);

    for (int mi = 0; mi < 3; mi++)
      for (int p = 0; p < 4; p++)
        for (int ri = 0; ri < 3; ri++)
          for (int h = 0; h < 3; h++)
            for (int s = 0; s < 4; s += 2)
              for (int fi = 0; fi < 2; fi++) begin
                m0 = modes[mi]; p0 = 4'(p); h0 = 4'(h); s0 = 4'(s);
                f0 = (fi == 0) ? 4'd1 : 4'd5;
                access(0, 1'b0, ad, 8'h00, rels[ri], 1'b0, 1'b0);
                access(0, 1'b1, ad + 8'd1, ~ad, 0, 1'b0, 1'b0);
                ad = ad + 8'd3;
                repeat (8) @(negedge clk);
                prev_rd_cs = -1;
              end

    m0 = 2'b10; s0 = 4; p0 = 2; h0 = 2; f0 = 0;
    access(0, 1'b0, 8'h40, 8'h00, 0, 1'b1, 1'b0);
    m0 = 2'b11; h0 = 4;
    access(0, 1'b0, 8'h50, 8'h00, 0, 1'b0, 1'b1);
    access(0, 1'b1, 8'h51, 8'hA5, 0, 1'b0, 1'b1);

    m0 = 2'b00; s0 = 1; p0 = 1; h0 = 1; f0 = 9;
    access(0, 1'b0, 8'h60, 8'h00, 0, 1'b0, 1'b0);
    access(1, 1'b1, 8'h61, 8'h3C, 0, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
    prev_rd_cs = -1;

    access(0, 1'b0, 8'h62, 8'h00, 0, 1'b0, 1'b0);
    access(0, 1'b1, 8'h63, 8'hC3, 0, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
    prev_rd_cs = -1;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_cs = 1'b1; req_addr = 8'h33; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 8'h77;
    chk(!req_ready, "R12 busy not ready", int'(req_ready), 0);
    @(negedge clk);
    chk(mem_addr == 8'h33, "R12 address held", int'(mem_addr), 8'h33);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(mem_cs_n == 2'b11, "R12 no second access", int'(mem_cs_n), 3);
    end
    chk(mem_addr == 8'h33, "R12 address after", int'(mem_addr), 8'h33);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule